// File: doc/BRIEF.md
# SPI Master Serial Clock and Strobe Generator

This block makes the serial clock for an SPI master from a fast peripheral clock. It also makes the single-cycle strobes that a neighbouring shift register uses to put out MOSI bits and to capture MISO bits. A 7-bit rate field sets the serial clock period in peripheral clock cycles. When the period is odd, the two levels of the clock differ in length by one peripheral cycle. Polarity selects the idle level of the clock. Phase selects whether each bit begins with the idle level or with the opposite level.

A pulse on the start input while the block is idle captures the rate, polarity, phase and bit-count inputs and begins a transfer. The block runs the programmed number of bits, returns the clock to its idle level and raises a one-cycle completion pulse. Input changes made while a transfer is running wait until the next start.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset is asserted, sclk_o equals cpol_i and launch_o, sample_o and done_o are 0.
- R2: The bit period D, measured from one launch_o pulse to the next, is baud_i+1 cycles when baud_i is 3 or more. It is 4 cycles when baud_i is 0, 1 or 2.
- R3: In each bit, the level opposite to idle lasts floor(D/2) cycles and the idle level lasts D-floor(D/2) cycles, so the two halves are equal when D is even.
- R4: When no transfer is running, sclk_o follows cpol_i: low for 0, high for 1.
- R5: With phase 0, each bit first holds the idle level and then the opposite level. launch_o pulses in the bit's first cycle, and sample_o pulses in the cycle in which sclk_o first takes the opposite level.
- R6: With phase 1, each bit first holds the opposite level and then the idle level. launch_o pulses in the cycle in which the leading edge appears, and sample_o pulses in the cycle in which sclk_o returns to idle.
- R7: start_i sampled high while idle starts a transfer whose first bit begins on the next cycle. The transfer runs nbits_i+1 bits. In the cycle after the last bit ends, done_o is 1 for exactly one cycle and sclk_o is at cpol_i.
- R8: Changes to baud_i, cpol_i, cpha_i or nbits_i during a transfer do not alter that transfer.
- R9: start_i asserted during a transfer is ignored.
- R10: launch_o and sample_o are each one-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer when idle |
| baud_i | input | 7 | Rate field; divisor is value+1, minimum 4 |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase select |
| nbits_i | input | 4 | Bits per transfer minus one |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Put out the next MOSI bit |
| sample_o | output | 1 | Capture MISO |
| done_o | output | 1 | One-cycle transfer-complete pulse |

## Verification
The hardest case to reach is a transfer whose configuration inputs and start input change partway through. Such changes must leave the clock pattern untouched, and the completion cycle must show the new idle level. To reach it, the stimulus flips polarity and phase, draws new rate and bit-count values and pulses start in the first cycle of a running transfer. It then compares every later cycle against a model built from the captured settings. Directed runs cover rate values 0 to 4, 126 and 127, and bit counts of one and sixteen.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  // Which half of a bit period is running.
  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/spi_div_calc.sv
module spi_div_calc #(
  parameter int BAUD_W = 7
) (
  input  logic [BAUD_W-1:0] baud_i,
  output logic [BAUD_W-1:0] short_o,
  output logic [BAUD_W-1:0] long_o
);
  localparam int DIV_W = BAUD_W + 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] rem;

  always_comb begin
    if (baud_i < BAUD_W'(3)) div = DIV_W'(4);
    else                     div = {1'b0, baud_i} + DIV_W'(1);
    rem = div - {1'b0, div[DIV_W-1:1]};
  end

  assign short_o = div[DIV_W-1:1];
  assign long_o  = rem[BAUD_W-1:0];
endmodule

// File: rtl/spi_phase_ctr.sv
module spi_phase_ctr
  import spi_baud_pkg::*;
#(
  parameter int HALF_W = 7,
  parameter int BITS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [HALF_W-1:0] len0_i,
  input  logic [HALF_W-1:0] len1_i,
  input  logic [BITS_W-1:0] last_bit_i,
  output logic              busy_o,
  output half_e             half_o,
  output logic              first_o,
  output logic              done_o
);
  logic              busy_q, busy_d;
  half_e             half_q, half_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [BITS_W-1:0] bit_q, bit_d;
  logic              done_q, done_d;
  logic [HALF_W-1:0] cur_len;

  always_comb begin
    busy_d  = busy_q;
    half_d  = half_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    cur_len = (half_q == HALF_LEAD) ? len0_i : len1_i;
    if (!busy_q) begin
      if (go_i) begin
        busy_d = 1'b1;
        half_d = HALF_LEAD;
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (cnt_q == cur_len - HALF_W'(1)) begin
      cnt_d = '0;
      if (half_q == HALF_LEAD) begin
        half_d = HALF_TRAIL;
      end else begin
        half_d = HALF_LEAD;
        if (bit_q == last_bit_i) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + BITS_W'(1);
        end
      end
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= HALF_LEAD;
      cnt_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      half_q <= half_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  assign busy_o  = busy_q;
  assign half_o  = half_q;
  assign first_o = (cnt_q == '0);
  assign done_o  = done_q;
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int BAUD_W = 7,
  parameter int BITS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [BITS_W-1:0] nbits_i,
  output logic              sclk_o,
  output logic              launch_o,
  output logic              sample_o,
  output logic              done_o
);
  localparam int HALF_W = BAUD_W;

  logic              rst_n;
  logic              busy, first, load;
  half_e             half;
  logic [BAUD_W-1:0] baud_q;
  logic              cpol_q, cpha_q;
  logic [BITS_W-1:0] nbits_q;
  logic [HALF_W-1:0] len_short, len_long, len0, len1;

  spi_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // Settings are captured only when a transfer is accepted.
  assign load = start_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      baud_q  <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      nbits_q <= '0;
    end else if (load) begin
      baud_q  <= baud_i;
      cpol_q  <= cpol_i;
      cpha_q  <= cpha_i;
      nbits_q <= nbits_i;
    end
  end

  spi_div_calc #(.BAUD_W(BAUD_W)) u_div (
    .baud_i  (baud_q),
    .short_o (len_short),
    .long_o  (len_long)
  );

  // The non-idle level always gets the short half.
  assign len0 = cpha_q ? len_short : len_long;
  assign len1 = cpha_q ? len_long  : len_short;

  spi_phase_ctr #(.HALF_W(HALF_W), .BITS_W(BITS_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .go_i       (start_i),
    .len0_i     (len0),
    .len1_i     (len1),
    .last_bit_i (nbits_q),
    .busy_o     (busy),
    .half_o     (half),
    .first_o    (first),
    .done_o     (done_o)
  );

  always_comb begin
    if (busy) sclk_o = cpol_q ^ ((half == HALF_LEAD) ? cpha_q : ~cpha_q);
    else      sclk_o = cpol_i;
  end

  assign launch_o = busy & (half == HALF_LEAD)  & first;
  assign sample_o = busy & (half == HALF_TRAIL) & first;
endmodule

// File: rtl/spi_baud_gen_chk.sv
module spi_baud_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic sclk_o,
  input logic launch_o,
  input logic sample_o,
  input logic done_o
);
  assert_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && sample_o));

  assert_launch_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);

  assert_sample_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // Sampling coincides with an SCLK edge in both phases (R6 as well).
  assert_sample_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sclk_o != $past(sclk_o)));

  assert_sclk_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> (launch_o || sample_o || done_o || !$stable(cpol_i)));

  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sclk_o == cpol_i));
endmodule

bind spi_baud_gen spi_baud_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cpol_i   (cpol_i),
  .sclk_o   (sclk_o),
  .launch_o (launch_o),
  .sample_o (sample_o),
  .done_o   (done_o)
);

// File: tb/tb_spi_baud_gen.sv
module tb_spi_baud_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [6:0] baud_i;
  logic       cpol_i, cpha_i;
  logic [3:0] nbits_i;
  logic       sclk_o, launch_o, sample_o, done_o;

  int checks = 0;
  int errors = 0;

  always #2ns clk_i = ~clk_i;

  spi_baud_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .baud_i(baud_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .nbits_i(nbits_i),
    .sclk_o(sclk_o), .launch_o(launch_o), .sample_o(sample_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(int baud);
    return (baud < 3) ? 4 : baud + 1;
  endfunction

  task automatic run_xfer(int baud, bit pol, bit pha, int nb, bit scramble);
    int d  = div_of(baud);
    int l0 = pha ? d / 2 : d - d / 2;
    string pre = scramble ? "R8 R9 " : "";
    @(negedge clk_i);
    baud_i = 7'(baud); cpol_i = pol; cpha_i = pha; nbits_i = 4'(nb); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int b = 0; b <= nb; b++) begin
      for (int p = 0; p < d; p++) begin
        bit es = pol ^ (pha ? (p < l0) : (p >= l0));
        chk(sclk_o == es, {pre, pha ? "R6 R3 sclk" : "R5 R3 sclk"}, sclk_o, es);
        chk(launch_o == (p == 0), {pre, "R2 launch"}, launch_o, p == 0);
        chk(sample_o == (p == l0), {pre, pha ? "R6 sample" : "R5 sample"}, sample_o, p == l0);
        chk(!done_o, {pre, "R7 done early"}, done_o, 0);
        chk(!(launch_o && sample_o), "R10 overlap", launch_o & sample_o, 0);
        if (scramble && b == 0 && p == 0) begin
          baud_i = 7'($urandom); cpol_i = ~pol; cpha_i = ~pha;
          nbits_i = 4'($urandom); start_i = 1'b1;
        end else begin
          start_i = 1'b0;
        end
        @(negedge clk_i);
      end
    end
    chk(done_o == 1'b1, {pre, "R7 done"}, done_o, 1);
    chk(sclk_o == cpol_i, "R7 idle at done", sclk_o, cpol_i);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done width", done_o, 0);
    chk(!launch_o && !sample_o, "R7 no strobe after", launch_o | sample_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; start_i = 1'b0; baud_i = '0; cpol_i = 1'b1; cpha_i = 1'b0; nbits_i = '0;
    repeat (3) @(negedge clk_i);
    chk(sclk_o == 1'b1, "R1 sclk pol1", sclk_o, 1);
    chk(!launch_o && !sample_o && !done_o, "R1 outputs", launch_o | sample_o | done_o, 0);
    cpol_i = 1'b0;
    @(negedge clk_i);
    chk(sclk_o == 1'b0, "R1 sclk pol0", sclk_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R4: idle level follows polarity
    cpol_i = 1'b1; #1ns;
    chk(sclk_o == 1'b1, "R4 idle high", sclk_o, 1);
    cpol_i = 1'b0; #1ns;
    chk(sclk_o == 1'b0, "R4 idle low", sclk_o, 0);
    // directed corners: small rates, odd/even, extremes, all modes
    for (int m = 0; m < 4; m++) begin
      run_xfer(0, m[1], m[0], 2, 1'b0);
      run_xfer(1, m[1], m[0], 0, 1'b0);
      run_xfer(2, m[1], m[0], 1, 1'b0);
      run_xfer(3, m[1], m[0], 3, 1'b0);
      run_xfer(4, m[1], m[0], 2, 1'b0);
      run_xfer(127, m[1], m[0], 1, 1'b0);
      run_xfer(126, m[1], m[0], 0, 1'b0);
    end
    run_xfer(6, 1'b0, 1'b1, 15, 1'b0);
    run_xfer(5, 1'b1, 1'b0, 15, 1'b1);
    // random stimulus, some with mid-transfer disturbance
    for (int i = 0; i < 40; i++) begin
      run_xfer(int'($urandom_range(0, 127)), 1'($urandom), 1'($urandom),
               int'($urandom_range(0, 15)), 1'($urandom));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule